// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Controller

This block holds the status byte and write-protection logic of a serial-peripheral-interface EEPROM slave. It watches the serial lines while chip select is low and decodes the first byte of each transaction as an instruction. It sets and clears the write enable latch. It returns the status byte for as long as the host keeps clocking after a status-read opcode. It loads the protect field and the lock bit from a two-byte status-write transaction. It also models the internal programming time with a timer that drives the busy flag.

The memory datapath sits outside the block and asks, one address at a time, whether a write may proceed. The block replies one clock later with a one-cycle "accepted" or "blocked" pulse. An accepted write starts a programming interval. The serial lines are oversampled by the system clock. The host's SCK must therefore be several system clocks per phase.

Top module: `spi_status_ctl`

## Requirements
- R1: After reset the status byte is 0x00, `busy_o` is low, `miso_oe_o` is low and neither `wr_accept_o` nor `wr_block_o` pulses.
- R2: Status byte layout: bit 0 busy flag, bit 1 enable latch, bits 3:2 protect field, bit 7 lock bit, bits 6:4 always 0. Opcode 0x05 (MSB first, sampled on rising SCK) reads it. During the opcode `miso_oe_o` is low. From the falling edge after the 8th clock the byte is driven MSB first on falling edges, and it repeats, refreshed at every byte boundary, while chip select stays low. This opcode is honoured even while busy.
- R3: Opcode 0x06 sets the enable latch and opcode 0x04 clears it, each on the 8th rising clock.
- R4: Opcode 0x01 (status write) is ignored when the enable latch is 0.
- R5: A status write loads data bit 7 into the lock bit and data bits 3:2 into the protect field only when chip select rises after exactly 16 clocks. With any other count nothing changes and the enable latch is kept.
- R6: An accepted status write or memory write holds the busy flag high for exactly PROG_CYCLES system clocks.
- R7: When a programming interval ends, the enable latch is cleared.
- R8: With the lock bit at 1 and `wp_ni` low, a status write is rejected and the lock bit and protect field cannot change.
- R9: Protect field 00 guards nothing, 01 guards the top quarter of the address space, 10 the top half and 11 everything. A write request gets `wr_accept_o` one clock later only if the enable latch is set, the block is idle and the address is unguarded. Otherwise it gets `wr_block_o` one clock later.
- R10: While busy, every opcode other than 0x05 is ignored and write requests are blocked.
- R11: If a status write commits in the same clock as a write request, the status write wins and the request is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| mosi_i | input | 1 | Serial data from host |
| wp_ni | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for `miso_o` (low = high impedance) |
| wr_req_i | input | 1 | Memory write request, one cycle |
| wr_addr_i | input | ADDR_W | Address of the requested write |
| wr_accept_o | output | 1 | Request accepted, programming started |
| wr_block_o | output | 1 | Request refused |
| busy_o | output | 1 | Programming interval running |

## Verification
Two functions can meet in one clock: a status write committing on the chip-select rise, and a memory write request arriving from the datapath. The bench lifts chip select and raises the request on the same falling system-clock edge, so the block sees both at one rising edge. It then expects a block pulse on the request and a busy flag owned by the status write. The final status read must show the newly written protect field. Byte-boundary refresh of the status during a continuous read, taken while the busy flag drops, is also judged byte by byte.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam int unsigned CNT_W = 5;
  localparam logic [CNT_W-1:0] WRSR_CLKS = 5'd16;
endpackage

// File: rtl/spi_sr_frontend.sv
module spi_sr_frontend
  import spi_sr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic [7:0]       status_i,
  output logic             op_valid_o,
  output logic             dat_valid_o,
  output logic [7:0]       byte_o,
  output logic             cs_rise_o,
  output logic [CNT_W-1:0] clk_cnt_o,
  output logic             miso_o,
  output logic             miso_oe_o
);
  logic             sck_q, cs_q, rise, fall, rd_act_q, oe_q, miso_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, obyte_q, byte_nxt;
  logic [2:0]       bit_q;

  assign rise      = !cs_ni && sck_i && !sck_q;
  assign fall      = !cs_ni && !sck_i && sck_q;
  assign cs_rise_o = cs_ni && !cs_q;
  assign byte_nxt  = {sh_q[6:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
    end else if (rise) begin
      sh_q <= byte_nxt;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign op_valid_o  = rise && (cnt_q == 5'd7);
  assign dat_valid_o = rise && (cnt_q == 5'd15);
  assign byte_o      = byte_nxt;
  assign clk_cnt_o   = cnt_q;

  // status byte re-sampled at each byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      oe_q     <= 1'b0;
      miso_q   <= 1'b0;
      bit_q    <= '0;
      obyte_q  <= '0;
    end else if (cs_ni) begin
      rd_act_q <= 1'b0;
      oe_q     <= 1'b0;
      bit_q    <= '0;
    end else begin
      if (op_valid_o && byte_nxt == OP_RDSR) rd_act_q <= 1'b1;
      if (fall && rd_act_q) begin
        oe_q  <= 1'b1;
        bit_q <= bit_q + 1'b1;
        if (bit_q == '0) begin
          obyte_q <= status_i;
          miso_q  <= status_i[7];
        end else begin
          miso_q <= obyte_q[3'd7 - bit_q];
        end
      end
    end
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = oe_q;

  p_oe_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> !cs_q);
  p_oe_after_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> rd_act_q);
endmodule

// File: rtl/spi_sr_prot.sv
module spi_sr_prot #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic              hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = addr_i[TOP] && addr_i[TOP-1];
      2'b10:   hit_o = addr_i[TOP];
      default: hit_o = 1'b1;
    endcase
  end

  initial begin
    a_addr_w_r9: assert (ADDR_W >= 2);
  end
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic             dat_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             cs_rise_i,
  input  logic [CNT_W-1:0] clk_cnt_i,
  input  logic             wp_ni,
  input  logic             wr_req_i,
  input  logic             wr_prot_i,
  output logic [7:0]       status_o,
  output logic [1:0]       bp_o,
  output logic             wr_accept_o,
  output logic             wr_block_o
);
  localparam int unsigned TW = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYCLES - 1);

  logic          wip_q, wel_q, srwd_q, pend_q, acc_q, blk_q;
  logic [1:0]    bp_q;
  logic [7:0]    dat_q;
  logic [TW-1:0] tmr_q;
  logic          hpm, commit, wr_ok, start, done;

  assign hpm    = srwd_q && !wp_ni;
  assign commit = cs_rise_i && pend_q && (clk_cnt_i == WRSR_CLKS) && !hpm && !wip_q;
  assign wr_ok  = wr_req_i && wel_q && !wip_q && !wr_prot_i && !commit;
  assign start  = commit || wr_ok;
  assign done   = wip_q && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q <= 1'b0;
      tmr_q <= '0;
    end else if (start) begin
      wip_q <= 1'b1;
      tmr_q <= T_LOAD;
    end else if (done) begin
      wip_q <= 1'b0;
    end else if (wip_q) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (done) begin
      wel_q <= 1'b0;
    end else if (op_valid_i && !wip_q) begin
      if (byte_i == OP_WREN)      wel_q <= 1'b1;
      else if (byte_i == OP_WRDI) wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      if (cs_rise_i) pend_q <= 1'b0;
      else if (op_valid_i && byte_i == OP_WRSR && wel_q && !wip_q && !hpm) pend_q <= 1'b1;
      if (dat_valid_i) dat_q <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q   <= '0;
      srwd_q <= 1'b0;
    end else if (commit) begin
      bp_q   <= dat_q[3:2];
      srwd_q <= dat_q[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      acc_q <= wr_ok;
      blk_q <= wr_req_i && !wr_ok;
    end
  end

  assign status_o    = {srwd_q, 3'b000, bp_q, wel_q, wip_q};
  assign bp_o        = bp_q;
  assign wr_accept_o = acc_q;
  assign wr_block_o  = blk_q;

  p_hpm_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpm |=> $stable(bp_q) && $stable(srwd_q));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && tmr_q != '0) |=> wip_q && $stable(wel_q) && $stable(bp_q) && $stable(srwd_q));
  p_end_clears_wel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
  p_start_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> tmr_q == T_LOAD);
  p_no_wel_no_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wel_q |=> !wr_accept_o);
  p_commit_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !wr_accept_o);
  p_one_reply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_q && blk_q));
endmodule

// File: rtl/spi_status_ctl.sv
module spi_status_ctl
  import spi_sr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PROG_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              wp_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              wr_accept_o,
  output logic              wr_block_o,
  output logic              busy_o
);
  logic             op_valid, dat_valid, cs_rise, prot_hit;
  logic [7:0]       rx_byte, status;
  logic [CNT_W-1:0] clk_cnt;
  logic [1:0]       bp;

  spi_sr_frontend u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck_i),
    .mosi_i      (mosi_i),
    .status_i    (status),
    .op_valid_o  (op_valid),
    .dat_valid_o (dat_valid),
    .byte_o      (rx_byte),
    .cs_rise_o   (cs_rise),
    .clk_cnt_o   (clk_cnt),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o)
  );

  spi_sr_prot #(.ADDR_W(ADDR_W)) u_prot (
    .addr_i (wr_addr_i),
    .bp_i   (bp),
    .hit_o  (prot_hit)
  );

  spi_sr_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid),
    .dat_valid_i (dat_valid),
    .byte_i      (rx_byte),
    .cs_rise_i   (cs_rise),
    .clk_cnt_i   (clk_cnt),
    .wp_ni       (wp_ni),
    .wr_req_i    (wr_req_i),
    .wr_prot_i   (prot_hit),
    .status_o    (status),
    .bp_o        (bp),
    .wr_accept_o (wr_accept_o),
    .wr_block_o  (wr_block_o)
  );

  assign busy_o = status[0];

  p_reply_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_accept_o || wr_block_o) |-> $past(wr_req_i));
endmodule

// File: tb/spi_status_ctl_tb.sv
module spi_status_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PROG = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic miso, miso_oe, wr_acc, wr_blk, busy;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_status_ctl #(.ADDR_W(AW), .PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .wp_ni(wp_n), .miso_o(miso), .miso_oe_o(miso_oe), .wr_req_i(wr_req),
    .wr_addr_i(wr_addr), .wr_accept_o(wr_acc), .wr_block_o(wr_blk), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] o, output logic oe_any);
    o = '0;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      tick(2);
      o[i] = miso;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
      tick(2);
    end
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [7:0] o;
    logic oe;
    cs_n = 1'b0; tick(2);
    spi_byte(op, o, oe);
    cs_n = 1'b1; tick(3);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic oe;
    cs_n = 1'b0; tick(2);
    spi_byte(8'h05, st, oe);
    chk("R2 high-Z during opcode", {7'd0, oe}, 8'h00);
    spi_byte(8'h00, st, oe);
    cs_n = 1'b1; tick(3);
  endtask

  task automatic wrsr(input logic [7:0] d, input bit extra);
    logic [7:0] o;
    logic oe;
    cs_n = 1'b0; tick(2);
    spi_byte(8'h01, o, oe);
    spi_byte(d, o, oe);
    if (extra) spi_byte(8'h00, o, oe);
    cs_n = 1'b1; tick(3);
  endtask

  task automatic wr_try(input logic [AW-1:0] a, input bit exp_acc, input string tag);
    wr_addr = a; wr_req = 1'b1;
    tick(1);
    wr_req = 1'b0;
    chk(tag, {6'd0, wr_acc, wr_blk}, exp_acc ? 8'h02 : 8'h01);
  endtask

  task automatic t_reset;
    logic [7:0] st;
    chk("R1 reset outputs", {4'd0, busy, miso_oe, wr_acc, wr_blk}, 8'h00);
    rdsr(st);
    chk("R1 reset status", st, 8'h00);
  endtask

  task automatic t_wel;
    logic [7:0] st;
    send_cmd(8'h06); rdsr(st);
    chk("R3 WREN sets latch", st, 8'h02);
    send_cmd(8'h04); rdsr(st);
    chk("R3 WRDI clears latch", st, 8'h00);
  endtask

  task automatic t_no_wel;
    logic [7:0] st;
    wrsr(8'h8C, 1'b0); rdsr(st);
    chk("R4 status write without latch ignored", st, 8'h00);
    wr_try(10'd0, 1'b0, "R9 write without latch blocked");
  endtask

  task automatic t_bad_count;
    logic [7:0] st;
    send_cmd(8'h06);
    wrsr(8'h8C, 1'b1); rdsr(st);
    chk("R5 24-clock status write ignored", st, 8'h02);
  endtask

  task automatic t_wrsr_stream;
    logic [7:0] o;
    logic oe;
    int busy_bytes = 0;
    wrsr(8'hFC, 1'b0);
    cs_n = 1'b0; tick(2);
    spi_byte(8'h05, o, oe);
    for (int i = 0; i < 10; i++) begin
      spi_byte(8'h00, o, oe);
      if (!o[0]) break;
      busy_bytes++;
      chk("R2 busy status during stream", o, 8'h8F);
    end
    cs_n = 1'b1; tick(3);
    chk("R7 status after cycle, bits 6:4 zero", o, 8'h8C);
    chk("R6 busy seen in stream", {7'd0, busy_bytes > 0}, 8'h01);
  endtask

  task automatic t_full_prot;
    send_cmd(8'h06);
    wr_try(10'd0, 1'b0, "R9 bp=11 guards address 0");
    wr_try(10'd1023, 1'b0, "R9 bp=11 guards top address");
  endtask

  task automatic t_hpm;
    logic [7:0] st;
    wp_n = 1'b0;
    wrsr(8'h00, 1'b0); rdsr(st);
    chk("R8 locked status write rejected", st, 8'h8E);
    wp_n = 1'b1;
    wrsr(8'h04, 1'b0);
    tick(PROG + 5);
    rdsr(st);
    chk("R5 unlocked status write commits", st, 8'h04);
  endtask

  task automatic t_quarter_timing;
    logic [7:0] st;
    send_cmd(8'h06);
    wr_try(10'd768, 1'b0, "R9 bp=01 guards 768");
    wr_try(10'd767, 1'b1, "R9 bp=01 accepts 767");
    chk("R6 busy right after accept", {7'd0, busy}, 8'h01);
    tick(PROG - 1);
    chk("R6 busy on last cycle", {7'd0, busy}, 8'h01);
    tick(1);
    chk("R6 busy ends after PROG_CYCLES", {7'd0, busy}, 8'h00);
    rdsr(st);
    chk("R7 latch cleared after write", st, 8'h04);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] st;
    send_cmd(8'h06);
    wr_try(10'd0, 1'b1, "R9 unguarded write accepted");
    send_cmd(8'h06);
    wr_try(10'd0, 1'b0, "R10 write blocked while busy");
    rdsr(st);
    chk("R2 status readable while busy", st, 8'h07);
    tick(PROG);
    rdsr(st);
    chk("R10 WREN ignored while busy", st, 8'h04);
  endtask

  task automatic t_half;
    logic [7:0] st;
    send_cmd(8'h06);
    wrsr(8'h08, 1'b0);
    tick(PROG + 5);
    send_cmd(8'h06);
    wr_try(10'd512, 1'b0, "R9 bp=10 guards 512");
    wr_try(10'd511, 1'b1, "R9 bp=10 accepts 511");
    tick(PROG + 5);
    rdsr(st);
    chk("R9 bp=10 status", st, 8'h08);
  endtask

  task automatic t_clash;
    logic [7:0] o, st;
    logic oe;
    send_cmd(8'h06);
    cs_n = 1'b0; tick(2);
    spi_byte(8'h01, o, oe);
    spi_byte(8'h00, o, oe);
    wr_addr = 10'd0;
    cs_n = 1'b1; wr_req = 1'b1;
    tick(1);
    wr_req = 1'b0;
    chk("R11 clash: request blocked", {6'd0, wr_acc, wr_blk}, 8'h01);
    chk("R11 clash: status write busy", {7'd0, busy}, 8'h01);
    tick(PROG + 5);
    rdsr(st);
    chk("R11 clash: status written", st, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_wel();
    t_no_wel();
    t_bad_count();
    t_wrsr_stream();
    t_full_prot();
    t_hpm();
    t_quarter_timing();
    t_busy_ignore();
    t_half();
    t_clash();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule